// File: doc/BRIEF.md
# Key Matrix Scanner with Debounce

This block walks through the rows of a key matrix one row at a time and reads the column sense lines for the row that is selected. If a closed column shows up, the block holds the row select on that row and watches the same key position for a fixed number of scan ticks. It accepts the key only if the key reads closed on every one of those ticks. An accepted key is packed into an 8-bit matrix address and announced by a one-clock push strobe, which a character buffer downstream can use as its write enable.

All movement happens on clocks where `scan_tick` is high, so the scan rate and the debounce time are set by how often the tick fires. The debounce length is the parameter `DEBOUNCE_TICKS`; a tick of about 1 ms and 12 ticks gives roughly 12 ms. A key that stays down is reported only once. The scan stays parked on that key's row until the key is released, and only then does it move on to the next row.

Top module: `kms_key_scanner`

## Requirements
- R1: Right after reset, `row_sel` is 0, `key_push` is 0 and `key_code` is 0.
- R2: On a scan tick in the scanning state with no closed column on the selected row, `row_sel` moves up by one. After row ROWS-1 it goes back to 0.
- R3: On a scan tick in the scanning state with a closed column on the selected row, debounce starts and `row_sel` stays on that row for the whole wait.
- R4: The key is accepted on the DEBOUNCE_TICKS-th scan tick after the detecting tick, provided it reads closed on each of those ticks. There is no push before that tick.
- R5: `key_code` is {1'b0, row[3:0], column[2:0]} for the accepted key. It is valid when the push occurs and is held until the next accepted key.
- R6: `key_push` is high for exactly one clock for each accepted key.
- R7: While an accepted key stays closed, no further push occurs and `row_sel` stays on its row. The first scan tick that reads it open returns the block to scanning and advances `row_sel` by one.
- R8: If the key reads open on any scan tick during the wait, it is discarded with no push, and `row_sel` advances by one on that tick.
- R9: If several columns are closed on the same row, the lowest-numbered column is the one captured.
- R10: On clocks where `scan_tick` is low, `row_sel` does not change and no push occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_tick | input | 1 | Scan step enable, one clock wide |
| col_sense | input | COLS | Column returns for the selected row, 1 = closed |
| row_sel | output | 4 | Binary code of the row being driven |
| key_code | output | 8 | Address of the last accepted key |
| key_push | output | 1 | One-clock strobe for each accepted key |

## Verification
The bench counts scan ticks to hit the exact acceptance tick. A counter that is off by one would push one tick early or one tick late, or would push the same key twice. It releases a key partway through the wait, and checks that a design which only looks at the key at the end of the wait, and so pushes a bounced key, is caught. It presses two columns on one row to catch a reversed priority encoder, uses the last row and the last column to catch wrong field packing and a missing wrap, and leaves the tick low with a key pressed to expose logic that moves without an enable.

// File: rtl/kms_pkg.sv
package kms_pkg;
  localparam int ROW_BITS = 4;
  localparam int COL_BITS = 3;
  localparam int CODE_W   = 8;

  typedef enum logic [1:0] {
    ST_SCAN   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } scan_state_t;

  // Pack an accepted key into its matrix address code.
  function automatic logic [CODE_W-1:0] pack_key(input logic [ROW_BITS-1:0] r,
                                                 input logic [COL_BITS-1:0] c);
    return {1'b0, r, c};
  endfunction

  // Next row in the scan order, wrapping at the last row.
  function automatic logic [ROW_BITS-1:0] step_row(input logic [ROW_BITS-1:0] r,
                                                   input int unsigned rows);
    if (32'(r) >= rows - 1) return '0;
    return r + 1'b1;
  endfunction
endpackage

// File: rtl/kms_row_seq.sv
module kms_row_seq
  import kms_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic [ROW_BITS-1:0] row_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (advance) row_q <= step_row(row_q, ROWS);
  end
endmodule

// File: rtl/kms_col_pick.sv
module kms_col_pick
  import kms_pkg::*;
#(
  parameter int COLS = 8
) (
  input  logic [COLS-1:0]     sense,
  output logic                any_hit,
  output logic [COL_BITS-1:0] first_idx
);
  logic [COLS-1:0] lowest;

  // One-hot mask of the lowest closed column.
  generate
    for (genvar i = 0; i < COLS; i++) begin : g_low
      if (i == 0) begin : g_first
        assign lowest[i] = sense[i];
      end else begin : g_rest
        assign lowest[i] = sense[i] & ~(|sense[i-1:0]);
      end
    end
  endgenerate

  always_comb begin
    first_idx = '0;
    for (int k = 0; k < COLS; k++) begin
      if (lowest[k]) first_idx = first_idx | COL_BITS'(k);
    end
  end

  assign any_hit = |sense;
endmodule

// File: rtl/kms_debounce_fsm.sv
module kms_debounce_fsm
  import kms_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        hit,
  input  logic        key_closed,
  output scan_state_t state,
  output logic        capture,
  output logic        advance,
  output logic        accept
);
  localparam int CNT_W = (DEBOUNCE_TICKS > 1) ? $clog2(DEBOUNCE_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(DEBOUNCE_TICKS - 1);

  scan_state_t      nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_load, cnt_dec;

  always_comb begin
    nxt      = state;
    capture  = 1'b0;
    advance  = 1'b0;
    accept   = 1'b0;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (tick) begin
      unique case (state)
        ST_SCAN: begin
          if (hit) begin
            capture  = 1'b1;
            cnt_load = 1'b1;
            nxt      = ST_SETTLE;
          end else begin
            advance = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (!key_closed) begin
            advance = 1'b1;
            nxt     = ST_SCAN;
          end else if (cnt_q == '0) begin
            accept = 1'b1;
            nxt    = ST_HELD;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        ST_HELD: begin
          if (!key_closed) begin
            advance = 1'b1;
            nxt     = ST_SCAN;
          end
        end
        default: nxt = ST_SCAN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_SCAN;
      cnt_q <= '0;
    end else begin
      state <= nxt;
      if (cnt_load)     cnt_q <= CNT_INIT;
      else if (cnt_dec) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/kms_key_scanner.sv
module kms_key_scanner
  import kms_pkg::*;
#(
  parameter int ROWS           = 8,
  parameter int COLS           = 8,
  parameter int DEBOUNCE_TICKS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scan_tick,
  input  logic [COLS-1:0] col_sense,
  output logic [3:0]      row_sel,
  output logic [7:0]      key_code,
  output logic            key_push
);
  scan_state_t         state;
  logic                col_hit;
  logic [COL_BITS-1:0] col_first;
  logic [COL_BITS-1:0] col_q;
  logic                key_closed;
  logic                capture_evt, advance_evt, accept_evt;
  logic                scan_active;

  kms_row_seq #(.ROWS(ROWS)) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance_evt),
    .row_q   (row_sel)
  );

  kms_col_pick #(.COLS(COLS)) u_pick (
    .sense     (col_sense),
    .any_hit   (col_hit),
    .first_idx (col_first)
  );

  assign key_closed  = col_sense[col_q];
  assign scan_active = (state == ST_SCAN);

  kms_debounce_fsm #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (scan_tick),
    .hit        (col_hit),
    .key_closed (key_closed),
    .state      (state),
    .capture    (capture_evt),
    .advance    (advance_evt),
    .accept     (accept_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      key_code <= '0;
      key_push <= 1'b0;
    end else begin
      key_push <= accept_evt;
      if (capture_evt) col_q    <= col_first;
      if (accept_evt)  key_code <= pack_key(row_sel, col_q);
    end
  end
endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scan_tick,
  input logic [COLS-1:0] col_sense,
  input logic [3:0]      row_sel,
  input logic [7:0]      key_code,
  input logic            key_push,
  input logic            scan_active,
  input logic            col_hit
);
  logic [COLS-1:0] sense_q;
  logic [3:0]      row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      row_q   <= '0;
    end else begin
      sense_q <= col_sense;
      row_q   <= row_sel;
    end
  end

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(row_sel) < ROWS); // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_tick && scan_active && !col_hit) |=>
      (row_sel == ((32'(row_q) == ROWS - 1) ? 4'd0 : row_q + 4'd1))); // R2
  AST_PUSH_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |=> !key_push); // R6
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_tick |=> ($stable(row_sel) && !key_push)); // R10
  AST_CODE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |-> (!key_code[7] && key_code[6:3] == row_sel)); // R5
  AST_PUSH_KEY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    key_push |-> sense_q[key_code[2:0]]); // R4
endmodule

bind kms_key_scanner kms_checker #(.ROWS(ROWS), .COLS(COLS)) u_kms_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .scan_tick   (scan_tick),
  .col_sense   (col_sense),
  .row_sel     (row_sel),
  .key_code    (key_code),
  .key_push    (key_push),
  .scan_active (scan_active),
  .col_hit     (col_hit)
);

// File: tb/kms_key_scanner_bench.sv
module kms_key_scanner_bench;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int DEB  = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            scan_tick = 1'b0;
  logic [COLS-1:0] col_sense;
  logic [3:0]      row_sel;
  logic [7:0]      key_code;
  logic            key_push;
  logic [COLS-1:0] keys [ROWS];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    col_sense = (32'(row_sel) < ROWS) ? keys[row_sel[2:0]] : '0;
  end

  kms_key_scanner #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE_TICKS(DEB)) u_kms_key_scanner (
    .clk       (clk),
    .rst_n     (rst_n),
    .scan_tick (scan_tick),
    .col_sense (col_sense),
    .row_sel   (row_sel),
    .key_code  (key_code),
    .key_push  (key_push)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int code_of(input int r, input int c);
    return (r << 3) | c;
  endfunction

  // One scan tick; returns at the following negedge with outputs updated.
  task automatic tick();
    @(negedge clk) scan_tick = 1'b1;
    @(negedge clk) scan_tick = 1'b0;
  endtask

  task automatic go_to_row(input int r);
    for (int n = 0; n < 2 * ROWS && 32'(row_sel) != r; n++) tick();
  endtask

  task automatic clear_keys();
    for (int r = 0; r < ROWS; r++) keys[r] = '0;
  endtask

  task automatic t_reset();
    chk(row_sel == 4'd0, "R1 row", row_sel, 0);
    chk(key_push == 1'b0, "R1 push", key_push, 0);
    chk(key_code == 8'd0, "R1 code", key_code, 0);
  endtask

  task automatic t_scan_wrap();
    bit ok = 1'b1;
    int exp_row;
    for (int n = 0; n < ROWS + 2; n++) begin
      exp_row = (row_sel == 4'(ROWS - 1)) ? 0 : row_sel + 1;
      tick();
      if (32'(row_sel) != exp_row) ok = 1'b0;
    end
    chk(ok, "R2 row step and wrap", row_sel, 2);
  endtask

  // Accept a key at (r,c) after walking to it; returns after the push.
  task automatic press_and_accept(input int r, input int c, input string tag);
    int pushes = 0;
    go_to_row(r);
    keys[r][c] = 1'b1;
    tick();
    chk(32'(row_sel) == r && !key_push, "R3 row held at detect", row_sel, r);
    for (int n = 1; n < DEB; n++) begin
      tick();
      if (key_push) pushes++;
    end
    chk(pushes == 0 && 32'(row_sel) == r, "R4 no early push", pushes, 0);
    tick();
    chk(key_push == 1'b1, "R4 push on last tick", key_push, 1);
    chk(32'(key_code) == code_of(r, c), tag, key_code, code_of(r, c));
  endtask

  task automatic t_clean_press();
    press_and_accept(3, 5, "R5 code row3 col5");
    @(negedge clk);
    chk(key_push == 1'b0, "R6 push one clock", key_push, 0);
    chk(key_code == 8'h1D, "R5 code held", key_code, 8'h1D);
  endtask

  task automatic t_held_then_release();
    int pushes = 0;
    for (int n = 0; n < 3 * DEB; n++) begin
      tick();
      if (key_push) pushes++;
    end
    chk(pushes == 0 && row_sel == 4'd3, "R7 held key single report", pushes, 0);
    keys[3][5] = 1'b0;
    tick();
    chk(row_sel == 4'd4 && !key_push, "R7 release advances row", row_sel, 4);
  endtask

  task automatic t_bounce();
    int pushes = 0;
    go_to_row(6);
    keys[6][1] = 1'b1;
    tick();
    tick();
    keys[6][1] = 1'b0;
    tick();
    chk(row_sel == 4'd7, "R8 bounce resumes scan", row_sel, 7);
    for (int n = 0; n < DEB + 2; n++) begin
      tick();
      if (key_push) pushes++;
    end
    chk(pushes == 0, "R8 bounced key discarded", pushes, 0);
    chk(key_code == 8'h1D, "R8 code untouched", key_code, 8'h1D);
  endtask

  task automatic t_two_columns();
    keys[2][6] = 1'b1;
    press_and_accept(2, 4, "R9 lowest column wins");
    clear_keys();
    tick();
    chk(row_sel == 4'd3, "R9 release", row_sel, 3);
  endtask

  task automatic t_corners();
    press_and_accept(7, 7, "R5 last row last col");
    keys[7] = '0;
    tick();
    chk(row_sel == 4'd0, "R2 wrap after release", row_sel, 0);
    press_and_accept(0, 0, "R5 row0 col0");
    keys[0] = '0;
    tick();
  endtask

  task automatic t_no_tick();
    int pushes = 0;
    logic [3:0] start;
    go_to_row(5);
    keys[5][2] = 1'b1;
    start = row_sel;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (key_push) pushes++;
    end
    chk(row_sel == start && pushes == 0, "R10 idle without tick", row_sel, start);
    tick();
    for (int n = 0; n < 10; n++) @(negedge clk);
    for (int n = 1; n < DEB; n++) tick();
    chk(!key_push, "R10 gaps do not count", key_push, 0);
    tick();
    chk(key_push && key_code == 8'h2A, "R4 accept after gapped ticks", key_code, 8'h2A);
    clear_keys();
    tick();
  endtask

  initial begin
    clear_keys();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan_wrap();
    t_clean_press();
    t_held_then_release();
    t_bounce();
    t_two_columns();
    t_corners();
    t_no_tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule